// File: doc/BRIEF.md
# Gated Capture-Compare Timer Channel

This block is a single channel of a general-purpose 16-bit timer. A free-running up-counter advances on a selectable count tick: every system clock, an externally supplied slow strobe, or rising edges of the capture pin. Two asynchronous pins feed the channel. The capture pin latches the counter into a capture register on a programmable edge. The gate pin starts and stops counting, and in one of its two modes it also clears the counter when counting starts.

When the counter reaches the programmed reference value, it wraps to zero on the following count tick. At that same match the channel drives its output pin, either as an active-low pulse lasting one count-tick period or as a level toggle. Capture and reference events latch into write-one-to-clear flags, and each flag has a mask bit that lets it drive a shared interrupt line. Software reaches the channel through a 64-byte window of 16-bit registers with per-byte write enables.

Top module: `gated_capture_timer`

## Requirements
- R1: Each pin passes through a two-flop synchronizer and then an edge detector. A capture-pin transition that settles before rising clock edge k loads the capture register at edge k+2, with the counter value held just before that edge. The capture flag is still clear after edge k+1.
- R2: CTRL[3:2] selects the capture edge: 0 = none, 1 = rising, 2 = falling, 3 = both. An edge that is not selected leaves the capture register and the capture flag unchanged.
- R3: On a selected capture edge, the capture register (offset 0x06, read-only) receives the counter value and EVT[0] is set.
- R4: EVT (offset 0x08) holds bit 0 = capture and bit 1 = reference match. Writing 1 to a bit through byte lane 0 clears it, and a new event in the same cycle wins over the clear. `irq` = (EVT[0] & CTRL[7]) | (EVT[1] & CTRL[8]).
- R5: CTRL[1:0] selects the tick source: 0 = every clock, 1 = `slowTick`, 2 = synchronized rising edges of the capture pin, 3 = no ticks. On each enabled tick the counter (offset 0x04) adds 1. A tick that finds the counter equal to REF (offset 0x02) loads 0 instead. A write to the counter takes priority over ticking.
- R6: With CTRL[4] = 0, the tick is always enabled. With CTRL[4] = 1, counting is off after reset. A synchronized falling gate edge enables counting and a rising edge disables it. In reset-gate mode (CTRL[5] = 0), the falling edge also clears the counter, and the first increment follows one clock later.
- R7: In normal-gate mode (CTRL[5] = 1), a falling gate edge resumes counting from the held value without clearing it.
- R8: With CTRL[6] = 1, `timerOut` goes low at the clock edge where the counter becomes equal to REF through a tick. It returns high at the next enabled tick.
- R9: With CTRL[6] = 0, `timerOut` inverts at every reference match.
- R10: Registers are 16-bit words at byte offsets 0x00 CTRL (bits 8:0), 0x02 REF, 0x04 CNT, 0x06 CAP and 0x08 EVT (bits 1:0). The word is selected by `busAddr[5:1]`. `busByteEn[0]` writes bits 7:0 and `busByteEn[1]` writes bits 15:8. All other offsets read 0, and writes to them change nothing.
- R11: After reset, CTRL = 0x0003, REF = 0xFFFF, CNT, CAP and EVT are all 0, `timerOut` = 1 and `irq` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| capturePin | input | 1 | Asynchronous capture input, also usable as the tick source |
| gatePin | input | 1 | Asynchronous gate input |
| slowTick | input | 1 | Slow count strobe, one clock wide |
| busAddr | input | 6 | Byte offset into the register window |
| busWrEn | input | 1 | Register write strobe |
| busByteEn | input | 2 | Byte-lane write enables |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for `busAddr`, combinational |
| timerOut | output | 1 | Reference-match output pin |
| irq | output | 1 | Masked event interrupt |

## Verification
A corrupted counter shows up in the count readback in the same cycle. It then shifts the pulse or toggle on `timerOut` and the reference flag at the next match, so a wrong wrap point becomes visible within one reference period. Errors in the synchronizer depth or the edge decoding move the capture value by one count, or set the capture flag one cycle early or late. The bench compares this against a model cycle by cycle. Wrong gate state freezes the count or lets it run in the cycle after a gate edge has been synchronized.

// File: rtl/gct_pkg.sv
package gct_pkg;

  // Tick source codes, CTRL[1:0]
  localparam logic [1:0] CLK_SYS  = 2'd0;
  localparam logic [1:0] CLK_SLOW = 2'd1;
  localparam logic [1:0] CLK_PIN  = 2'd2;
  localparam logic [1:0] CLK_HALT = 2'd3;

  // Capture edge codes, CTRL[3:2]
  localparam logic [1:0] EDGE_OFF  = 2'd0;
  localparam logic [1:0] EDGE_RISE = 2'd1;
  localparam logic [1:0] EDGE_FALL = 2'd2;
  localparam logic [1:0] EDGE_BOTH = 2'd3;

  // Word indices inside the register window
  localparam int REG_CTRL = 0;
  localparam int REG_REF  = 1;
  localparam int REG_CNT  = 2;
  localparam int REG_CAP  = 3;
  localparam int REG_EVT  = 4;

  // CTRL layout, MSB first
  typedef struct packed {
    logic       refMask;    // 8
    logic       capMask;    // 7
    logic       outPulse;   // 6
    logic       gateNormal; // 5
    logic       gateEn;     // 4
    logic [1:0] capEdge;    // 3:2
    logic [1:0] clkSel;     // 1:0
  } gctCfg_t;

  localparam int CFG_W = $bits(gctCfg_t);
  localparam logic [CFG_W-1:0] CFG_RESET = CFG_W'(3);

  // Control to datapath strobes
  typedef struct packed {
    logic tick;
    logic restart;
    logic capture;
  } gctStrobe_t;

endpackage

// File: rtl/gct_sync.sv
module gct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/gct_ctrl.sv
module gct_ctrl
  import gct_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       capturePin,
  input  logic       gatePin,
  input  logic       slowTick,
  input  gctCfg_t    cfg,
  output gctStrobe_t stb
);

  localparam int PIN_CNT  = 2;
  localparam int PIN_CAP  = 0;
  localparam int PIN_GATE = 1;

  logic [PIN_CNT-1:0] rawPins, syncPins, prevPins, risePins, fallPins;
  logic runQ, runNow, tickSrc, capHit;

  assign rawPins = {gatePin, capturePin};

  for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
    gct_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rstN (rstN),
      .din  (rawPins[p]),
      .dout (syncPins[p])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevPins <= '0;
    else       prevPins <= syncPins;
  end

  assign risePins = syncPins & ~prevPins;
  assign fallPins = ~syncPins & prevPins;

  // Gate run state: falling edge opens, rising edge closes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  runQ <= 1'b0;
    else if (fallPins[PIN_GATE]) runQ <= 1'b1;
    else if (risePins[PIN_GATE]) runQ <= 1'b0;
  end

  assign runNow = !cfg.gateEn || runQ;

  always_comb begin
    unique case (cfg.clkSel)
      CLK_SYS:  tickSrc = 1'b1;
      CLK_SLOW: tickSrc = slowTick;
      CLK_PIN:  tickSrc = risePins[PIN_CAP];
      default:  tickSrc = 1'b0;
    endcase
  end

  always_comb begin
    unique case (cfg.capEdge)
      EDGE_RISE: capHit = risePins[PIN_CAP];
      EDGE_FALL: capHit = fallPins[PIN_CAP];
      EDGE_BOTH: capHit = risePins[PIN_CAP] | fallPins[PIN_CAP];
      default:   capHit = 1'b0;
    endcase
  end

  assign stb.tick    = tickSrc && runNow;
  assign stb.restart = cfg.gateEn && !cfg.gateNormal && fallPins[PIN_GATE];
  assign stb.capture = capHit;

  // R6: a rising gate edge stops the following tick while gating stays on
  p_gate_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.gateEn && risePins[PIN_GATE]) ##1 cfg.gateEn |-> !stb.tick);

  // R6: a falling gate edge lets the system-clock tick through one clock later
  p_gate_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.gateEn && fallPins[PIN_GATE]) ##1 (cfg.gateEn && cfg.clkSel == CLK_SYS) |-> stb.tick);

  // R2: no capture strobe while capture is disabled
  p_cap_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.capEdge == EDGE_OFF) |-> !stb.capture);

endmodule

// File: rtl/gct_datapath.sv
module gct_datapath
  import gct_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gctStrobe_t           stb,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [CNT_W/8-1:0]   busByteEn,
  input  logic [CNT_W-1:0]     busWrData,
  output logic [CNT_W-1:0]     busRdData,
  output gctCfg_t              cfg,
  output logic                 timerOut,
  output logic                 irq
);

  localparam int LANES  = CNT_W / 8;
  localparam int WORD_W = ADDR_W - 1;
  localparam int EVT_W  = 2;
  localparam logic [WORD_W-1:0] IDX_CTRL = WORD_W'(REG_CTRL);
  localparam logic [WORD_W-1:0] IDX_REF  = WORD_W'(REG_REF);
  localparam logic [WORD_W-1:0] IDX_CNT  = WORD_W'(REG_CNT);
  localparam logic [WORD_W-1:0] IDX_CAP  = WORD_W'(REG_CAP);
  localparam logic [WORD_W-1:0] IDX_EVT  = WORD_W'(REG_EVT);

  logic [WORD_W-1:0] wordIdx;
  logic [CFG_W-1:0]  ctrlReg;
  logic [CNT_W-1:0]  refReg, cntReg, capReg, cntNext, ctrlMerged;
  logic [EVT_W-1:0]  evtReg, evtSet, evtClr;
  logic ctrlWr, refWr, cntWr, evtWr, refHit, toggleQ, pulseQ;
  logic unusedBusBits;

  function automatic logic [CNT_W-1:0] mergeBytes(
    input logic [CNT_W-1:0] oldVal,
    input logic [CNT_W-1:0] newVal,
    input logic [LANES-1:0] laneEn
  );
    logic [CNT_W-1:0] res;
    res = oldVal;
    for (int l = 0; l < LANES; l++) begin
      if (laneEn[l]) res[l*8 +: 8] = newVal[l*8 +: 8];
    end
    return res;
  endfunction

  assign wordIdx = busAddr[ADDR_W-1:1];
  assign ctrlWr  = busWrEn && wordIdx == IDX_CTRL;
  assign refWr   = busWrEn && wordIdx == IDX_REF;
  assign cntWr   = busWrEn && wordIdx == IDX_CNT;
  assign evtWr   = busWrEn && wordIdx == IDX_EVT;

  assign ctrlMerged    = mergeBytes(CNT_W'(ctrlReg), busWrData, busByteEn);
  assign unusedBusBits = busAddr[0] ^ (^ctrlMerged[CNT_W-1:CFG_W]);
  assign cfg           = gctCfg_t'(ctrlReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= CFG_RESET;
      refReg  <= '1;
    end else begin
      if (ctrlWr) ctrlReg <= ctrlMerged[CFG_W-1:0];
      if (refWr)  refReg  <= mergeBytes(refReg, busWrData, busByteEn);
    end
  end

  // Counter with wrap on the tick that finds it at the reference
  assign cntNext = (cntReg == refReg) ? '0 : cntReg + 1'b1;
  assign refHit  = stb.tick && !cntWr && !stb.restart && cntNext == refReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntReg <= '0;
    else if (cntWr)       cntReg <= mergeBytes(cntReg, busWrData, busByteEn);
    else if (stb.restart) cntReg <= '0;
    else if (stb.tick)    cntReg <= cntNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            capReg <= '0;
    else if (stb.capture) capReg <= cntReg;
  end

  // Event flags: set beats clear
  assign evtSet = {refHit, stb.capture};
  assign evtClr = (evtWr && busByteEn[0]) ? busWrData[EVT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtReg <= '0;
    else       evtReg <= (evtReg & ~evtClr) | evtSet;
  end

  assign irq = (evtReg[0] && cfg.capMask) || (evtReg[1] && cfg.refMask);

  // Output pin state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toggleQ <= 1'b1;
      pulseQ  <= 1'b0;
    end else begin
      if (refHit) toggleQ <= ~toggleQ;
      if (refHit)        pulseQ <= 1'b1;
      else if (stb.tick) pulseQ <= 1'b0;
    end
  end

  assign timerOut = cfg.outPulse ? ~pulseQ : toggleQ;

  always_comb begin
    busRdData = '0;
    unique case (wordIdx)
      IDX_CTRL: busRdData = CNT_W'(ctrlReg);
      IDX_REF:  busRdData = refReg;
      IDX_CNT:  busRdData = cntReg;
      IDX_CAP:  busRdData = capReg;
      IDX_EVT:  busRdData = CNT_W'(evtReg);
      default:  busRdData = '0;
    endcase
  end

  // R3: capture register receives the counter value of the strobe cycle
  p_capture_copy_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> capReg == $past(cntReg));

  // R5: a tick at the reference brings the counter back to zero
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tick && !cntWr && !stb.restart && cntReg == refReg) |=> cntReg == '0);

  // R4: an unmasked capture event raises the interrupt
  p_cap_irq_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && cfg.capMask) ##1 cfg.capMask |-> irq);

  // R8: pulse mode drives the pin low after a reference match
  p_pulse_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.outPulse && refHit) ##1 cfg.outPulse |-> !timerOut);

  // R9: toggle mode flips the pin on a reference match
  p_toggle_flip_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.outPulse && refHit) ##1 !cfg.outPulse |-> timerOut != $past(timerOut));

endmodule

// File: rtl/gated_capture_timer.sv
module gated_capture_timer
  import gct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 capturePin,
  input  logic                 gatePin,
  input  logic                 slowTick,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [CNT_W/8-1:0]   busByteEn,
  input  logic [CNT_W-1:0]     busWrData,
  output logic [CNT_W-1:0]     busRdData,
  output logic                 timerOut,
  output logic                 irq
);

  gctCfg_t    cfg;
  gctStrobe_t stb;

  gct_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .capturePin (capturePin),
    .gatePin    (gatePin),
    .slowTick   (slowTick),
    .cfg        (cfg),
    .stb        (stb)
  );

  gct_datapath #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busByteEn (busByteEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .cfg       (cfg),
    .timerOut  (timerOut),
    .irq       (irq)
  );

endmodule

// File: tb/gated_capture_timer_bench.sv
module gated_capture_timer_bench;

  localparam int CLK_PERIOD = 20;

  logic clk = 1'b0;
  logic rstN;
  logic capturePin, gatePin, slowTick;
  logic [5:0]  busAddr;
  logic        busWrEn;
  logic [1:0]  busByteEn;
  logic [15:0] busWrData, busRdData;
  logic timerOut, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_capture_timer u_gated_capture_timer (
    .clk(clk), .rstN(rstN), .capturePin(capturePin), .gatePin(gatePin),
    .slowTick(slowTick), .busAddr(busAddr), .busWrEn(busWrEn),
    .busByteEn(busByteEn), .busWrData(busWrData), .busRdData(busRdData),
    .timerOut(timerOut), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit capDrv, gateDrv, slowDrv;

  // Reference model state
  logic [8:0]  mCtrl;
  logic [15:0] mRef, mCnt, mCap;
  logic [1:0]  mEvt;
  logic mTog, mPul, mRun, mc1, mc2, mc3, mg1, mg2, mg3;

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic readReg(logic [5:0] a, output logic [15:0] v);
    busWrEn = 1'b0;
    busAddr = a;
    #1;
    v = busRdData;
  endtask

  function automatic logic [15:0] mergeLanes(logic [15:0] o, logic [15:0] d, logic [1:0] be);
    logic [15:0] r;
    r = o;
    if (be[0]) r[7:0]  = d[7:0];
    if (be[1]) r[15:8] = d[15:8];
    return r;
  endfunction

  function automatic logic [15:0] expOut();
    return {15'd0, mCtrl[6] ? ~mPul : mTog};
  endfunction

  function automatic logic [15:0] expIrq();
    return {15'd0, (mEvt[0] & mCtrl[7]) | (mEvt[1] & mCtrl[8])};
  endfunction

  task automatic modelReset();
    mCtrl = 9'h003; mRef = 16'hFFFF; mCnt = '0; mCap = '0; mEvt = '0;
    mTog = 1'b1; mPul = 1'b0; mRun = 1'b0;
    {mc1, mc2, mc3, mg1, mg2, mg3} = '0;
  endtask

  task automatic modelStep(bit wr, logic [5:0] a, logic [1:0] be, logic [15:0] d,
                           bit capIn, bit gateIn, bit slowIn);
    logic cR, cF, gR, gF, src, run, tk, rst, cHit, cntWr, hit;
    logic [15:0] nxt, tmp;
    logic [4:0] idx;
    logic [1:0] clr;
    cR = mc2 & ~mc3; cF = ~mc2 & mc3;
    gR = mg2 & ~mg3; gF = ~mg2 & mg3;
    case (mCtrl[1:0])
      2'd0: src = 1'b1;
      2'd1: src = slowIn;
      2'd2: src = cR;
      default: src = 1'b0;
    endcase
    run = !mCtrl[4] || mRun;
    tk  = src && run;
    rst = mCtrl[4] && gF && !mCtrl[5];
    case (mCtrl[3:2])
      2'd1: cHit = cR;
      2'd2: cHit = cF;
      2'd3: cHit = cR | cF;
      default: cHit = 1'b0;
    endcase
    idx   = a[5:1];
    cntWr = wr && idx == 5'd2;
    nxt   = (mCnt == mRef) ? 16'd0 : mCnt + 16'd1;
    hit   = tk && !cntWr && !rst && nxt == mRef;
    if (cHit) mCap = mCnt;
    clr  = (wr && idx == 5'd4 && be[0]) ? d[1:0] : 2'b00;
    mEvt = (mEvt & ~clr) | {hit, cHit};
    if (hit) mTog = ~mTog;
    if (hit) mPul = 1'b1; else if (tk) mPul = 1'b0;
    if (cntWr)    mCnt = mergeLanes(mCnt, d, be);
    else if (rst) mCnt = 16'd0;
    else if (tk)  mCnt = nxt;
    if (gF) mRun = 1'b1; else if (gR) mRun = 1'b0;
    if (wr && idx == 5'd0) begin
      tmp = mergeLanes({7'd0, mCtrl}, d, be);
      mCtrl = tmp[8:0];
    end
    if (wr && idx == 5'd1) mRef = mergeLanes(mRef, d, be);
    mc3 = mc2; mc2 = mc1; mc1 = capIn;
    mg3 = mg2; mg2 = mg1; mg1 = gateIn;
  endtask

  task automatic compareAll();
    logic [15:0] v;
    readReg(6'h00, v); check("R10", "ctrl", v, {7'd0, mCtrl});
    readReg(6'h02, v); check("R10", "ref", v, mRef);
    readReg(6'h04, v); check("R5", "count", v, mCnt);
    readReg(6'h06, v); check("R3", "capture", v, mCap);
    readReg(6'h08, v); check("R4", "events", v, {14'd0, mEvt});
    check(mCtrl[6] ? "R8" : "R9", "timerOut", {15'd0, timerOut}, expOut());
    check("R4", "irq", {15'd0, irq}, expIrq());
  endtask

  task automatic cyc(bit wr, logic [5:0] a, logic [1:0] be, logic [15:0] d);
    busWrEn = wr; busAddr = a; busByteEn = be; busWrData = d;
    capturePin = capDrv; gatePin = gateDrv; slowTick = slowDrv;
    @(posedge clk);
    modelStep(wr, a, be, d, capDrv, gateDrv, slowDrv);
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 6'h00, 2'b00, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c0;
    int toggles;
    logic prevOut;
    void'($urandom(32'h00C0FFEE));
    rstN = 1'b0; capDrv = 1'b0; gateDrv = 1'b1; slowDrv = 1'b0;
    capturePin = 1'b0; gatePin = 1'b1; slowTick = 1'b0;
    busWrEn = 1'b0; busAddr = '0; busByteEn = '0; busWrData = '0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R11: reset state
    readReg(6'h00, v); check("R11", "ctrl reset", v, 16'h0003);
    readReg(6'h02, v); check("R11", "ref reset", v, 16'hFFFF);
    readReg(6'h04, v); check("R11", "count reset", v, 16'h0000);
    readReg(6'h08, v); check("R11", "events reset", v, 16'h0000);
    check("R11", "timerOut reset", {15'd0, timerOut}, 16'd1);
    check("R11", "irq reset", {15'd0, irq}, 16'd0);

    // R10: unused offsets read zero, writes there are ignored
    for (int a = 10; a < 64; a += 2) begin
      idle(1);
      readReg(6'(a), v); check("R10", "unused read", v, 16'h0000);
    end
    cyc(1'b1, 6'h20, 2'b11, 16'hFFFF);
    readReg(6'h00, v); check("R10", "ctrl after unused write", v, 16'h0003);

    // R1: synchronizer latency into capture
    cyc(1'b1, 6'h00, 2'b11, 16'h0084);
    idle(3);
    readReg(6'h04, c0);
    capDrv = 1'b1;
    idle(2);
    readReg(6'h08, v); check("R1", "no capture flag after k+1", v & 16'h1, 16'h0);
    idle(1);
    readReg(6'h06, v); check("R1", "capture at k+2", v, c0 + 16'd2);
    readReg(6'h08, v); check("R3", "capture flag", v & 16'h1, 16'h1);
    check("R4", "irq on capture", {15'd0, irq}, 16'd1);
    cyc(1'b1, 6'h08, 2'b01, 16'h0001);
    readReg(6'h08, v); check("R4", "flag cleared", v, 16'h0);

    // R2: edge selection
    cyc(1'b1, 6'h00, 2'b11, 16'h0088);
    capDrv = 1'b0; idle(4);
    readReg(6'h08, v); check("R2", "falling edge captured", v & 16'h1, 16'h1);
    cyc(1'b1, 6'h08, 2'b01, 16'h0003);
    capDrv = 1'b1; idle(5);
    readReg(6'h08, v); check("R2", "rising ignored in fall mode", v & 16'h1, 16'h0);
    cyc(1'b1, 6'h00, 2'b11, 16'h0080);
    capDrv = 1'b0; idle(5);
    readReg(6'h08, v); check("R2", "disabled capture", v & 16'h1, 16'h0);
    cyc(1'b1, 6'h00, 2'b11, 16'h008C);
    capDrv = 1'b1; idle(4);
    readReg(6'h08, v); check("R2", "both edges", v & 16'h1, 16'h1);
    cyc(1'b1, 6'h08, 2'b01, 16'h0003);

    // R6: reset-gate mode
    cyc(1'b1, 6'h00, 2'b11, 16'h0010);
    cyc(1'b1, 6'h04, 2'b11, 16'd50);
    idle(2);
    readReg(6'h04, v); check("R6", "gated off holds", v, 16'd50);
    gateDrv = 1'b0; idle(3);
    readReg(6'h04, v); check("R6", "restart clears", v, 16'd0);
    idle(2);
    readReg(6'h04, v); check("R6", "counting after restart", v, 16'd2);
    readReg(6'h04, c0);
    gateDrv = 1'b1; idle(6);
    readReg(6'h04, v); check("R6", "rising gate stops", v, c0 + 16'd3);

    // R7: normal-gate mode keeps the count
    cyc(1'b1, 6'h00, 2'b11, 16'h0030);
    readReg(6'h04, c0);
    gateDrv = 1'b0; idle(5);
    readReg(6'h04, v); check("R7", "resume without clear", v, c0 + 16'd2);

    // R8: pulse mode on the system clock
    cyc(1'b1, 6'h00, 2'b11, 16'h0140);
    cyc(1'b1, 6'h02, 2'b11, 16'd10);
    cyc(1'b1, 6'h04, 2'b11, 16'd5);
    for (int i = 0; i < 30; i++) begin
      idle(1);
      readReg(6'h04, v);
      check("R8", "pulse vs count", {15'd0, timerOut}, {15'd0, v != 16'd10});
    end
    // R8: pulse width follows the slow tick
    cyc(1'b1, 6'h00, 2'b11, 16'h0141);
    for (int i = 0; i < 60; i++) begin
      slowDrv = (i % 4) == 0;
      idle(1);
      readReg(6'h04, v);
      check("R8", "slow pulse vs count", {15'd0, timerOut}, {15'd0, v != 16'd10});
    end
    slowDrv = 1'b0;

    // R9: toggle mode flips twice in 22 system clocks with REF = 10
    cyc(1'b1, 6'h00, 2'b11, 16'h0100);
    toggles = 0;
    prevOut = timerOut;
    for (int i = 0; i < 22; i++) begin
      idle(1);
      if (timerOut != prevOut) toggles++;
      prevOut = timerOut;
    end
    check("R9", "toggle count", 16'(toggles), 16'd2);

    // Constrained random phase checked against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] a;
      logic [15:0] d;
      bit wr;
      if ($urandom % 6 == 0)  capDrv  = ~capDrv;
      if ($urandom % 10 == 0) gateDrv = ~gateDrv;
      slowDrv = ($urandom % 3) == 0;
      wr = ($urandom % 10) == 0;
      d  = 16'($urandom);
      case ($urandom % 6)
        0: a = 6'h00;
        1: begin a = 6'h02; d = 16'($urandom % 40); end
        2: begin a = 6'h04; d = 16'($urandom % 40); end
        3: a = 6'h06;
        4: a = 6'h08;
        default: a = 6'(10 + 2 * ($urandom % 27));
      endcase
      a[0] = 1'($urandom % 2);
      cyc(wr, a, 2'($urandom % 4), d);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule